// File: doc/BRIEF.md
# Registered 8-bit ALU with N/V/Z/C flag generation

This block is the arithmetic and logic stage of a small 8-bit processor that works in binary mode. Each cycle it takes an operation code, a register operand (the accumulator or an index register), a memory operand, the current carry and the current N, V and Z flags. It produces a result and a new set of flags. Both are registered, so they appear one clock after the inputs are sampled.

A four-bit write mask goes with every result and names the flags that the operation defines. Every flag outside the mask is returned unchanged from its incoming value, so the surrounding datapath can write back all four flags without any decoding of its own. Decimal correction, operand fetch and register writeback belong to the neighbouring logic. The width is a parameter with a default of 8. The top two operand bits play the roles of "bit 7" and "bit 6" below.

Top module: `alu_flags`

## Requirements
- R1: While `rst_n` is low, `result`, all four flag outputs and `flag_wr` are zero.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: Code 0 (add with carry): result = reg + mem + C modulo 2^W. C is set on an unsigned carry out of the top bit. V is set when both operands have the same sign bit and the result's sign bit differs from it. Writes N, V, Z, C.
- R4: Code 1 (subtract with borrow): result = reg − mem − (C clear ? 1 : 0) modulo 2^W. C is set when no borrow occurred. V is the top bit of (reg XOR mem) AND (reg XOR result). Writes N, V, Z, C.
- R5: Code 2 (compare): result = reg unchanged. C = (reg ≥ mem, unsigned), Z = (reg == mem), N = top bit of (reg − mem) modulo 2^W. Writes N, Z, C.
- R6: Code 3 (bit test): result = reg unchanged. Z = ((reg AND mem) == 0), V = operand bit W−2, N = operand bit W−1. Writes N, V, Z.
- R7: Codes 4, 5 and 6 give reg AND mem, reg OR mem and reg XOR mem. They write only N and Z.
- R8: Code 7 (increment reg) and code 8 (decrement reg) wrap modulo 2^W and write only N and Z. C is returned unchanged.
- R9: Code 9 shifts reg left (0 enters bit 0, C takes the old top bit). Code 10 shifts right (0 enters the top bit, C takes the old bit 0). Both write N, Z, C.
- R10: Code 11 rotates left (old C enters bit 0, C takes the old top bit). Code 12 rotates right (old C enters the top bit, C takes the old bit 0). Both write N, Z, C.
- R11: Codes 13 to 15 pass reg through unchanged with an empty write mask.
- R12: `flag_wr` bit 3 is N, bit 2 is V, bit 1 is Z and bit 0 is C. For every written flag, N is the result's top bit and Z is (result == 0), unless the operation defines its own rule. Each flag whose mask bit is clear leaves the block equal to its incoming value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code (see R3 to R11) |
| reg_in | input | W | Register operand |
| mem_in | input | W | Memory operand |
| c_in | input | 1 | Incoming carry |
| n_in | input | 1 | Incoming negative flag |
| v_in | input | 1 | Incoming overflow flag |
| z_in | input | 1 | Incoming zero flag |
| result | output | W | Registered result |
| n_out | output | 1 | Registered negative flag |
| v_out | output | 1 | Registered overflow flag |
| z_out | output | 1 | Registered zero flag |
| c_out | output | 1 | Registered carry flag |
| flag_wr | output | 4 | Registered flag write mask {N,V,Z,C} |

## Verification
The bench builds the block with W = 4. At that width every operation code can be combined with every register value, every memory value and both carry states, 8192 vectors in all. This covers every signed-overflow boundary, every compare edge case (equal, one above, one below) and every wrap of increment and decrement. The incoming N, V and Z values change from vector to vector, so a flag that leaks instead of being held shows up under some pattern. The expected values come from integer and signed-range arithmetic rather than bit operations.

// File: rtl/alu_flags.sv
`timescale 1ns/1ps
module alu_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [W-1:0] reg_in,
  input  logic [W-1:0] mem_in,
  input  logic         c_in,
  input  logic         n_in,
  input  logic         v_in,
  input  logic         z_in,
  output logic [W-1:0] result,
  output logic         n_out,
  output logic         v_out,
  output logic         z_out,
  output logic         c_out,
  output logic [3:0]   flag_wr
);
  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADC = 4'd0, OP_SBC = 4'd1, OP_CMP = 4'd2, OP_BIT = 4'd3,
                         OP_AND = 4'd4, OP_ORA = 4'd5, OP_EOR = 4'd6, OP_INC = 4'd7,
                         OP_DEC = 4'd8, OP_ASL = 4'd9, OP_LSR = 4'd10, OP_ROL = 4'd11,
                         OP_ROR = 4'd12;

  logic [W:0] add_s, sub_s, cmp_s;
  assign add_s = {1'b0, reg_in} + {1'b0, mem_in}  + {{W{1'b0}}, c_in};
  assign sub_s = {1'b0, reg_in} + {1'b0, ~mem_in} + {{W{1'b0}}, c_in};
  assign cmp_s = {1'b0, reg_in} + {1'b0, ~mem_in} + {{W{1'b0}}, 1'b1};

  logic [W-1:0] r;
  logic         n, v, z, c;
  logic [3:0]   m;

  always_comb begin
    r = reg_in;
    v = v_in;
    c = c_in;
    m = 4'b0000;
    case (op)
      OP_ADC: begin
        r = add_s[MSB:0];
        c = add_s[W];
        v = (reg_in[MSB] == mem_in[MSB]) && (r[MSB] != reg_in[MSB]);
        m = 4'b1111;
      end
      OP_SBC: begin
        r = sub_s[MSB:0];
        c = sub_s[W];
        v = (reg_in[MSB] ^ mem_in[MSB]) & (reg_in[MSB] ^ r[MSB]);
        m = 4'b1111;
      end
      OP_CMP: begin c = cmp_s[W]; m = 4'b1011; end
      OP_BIT: begin v = mem_in[MSB-1]; m = 4'b1110; end
      OP_AND: begin r = reg_in & mem_in; m = 4'b1010; end
      OP_ORA: begin r = reg_in | mem_in; m = 4'b1010; end
      OP_EOR: begin r = reg_in ^ mem_in; m = 4'b1010; end
      OP_INC: begin r = reg_in + 1'b1; m = 4'b1010; end
      OP_DEC: begin r = reg_in - 1'b1; m = 4'b1010; end
      OP_ASL: begin r = {reg_in[MSB-1:0], 1'b0}; c = reg_in[MSB]; m = 4'b1011; end
      OP_LSR: begin r = {1'b0, reg_in[MSB:1]};   c = reg_in[0];   m = 4'b1011; end
      OP_ROL: begin r = {reg_in[MSB-1:0], c_in}; c = reg_in[MSB]; m = 4'b1011; end
      OP_ROR: begin r = {c_in, reg_in[MSB:1]};   c = reg_in[0];   m = 4'b1011; end
      default: ;
    endcase
    case (op)
      OP_CMP:  begin n = cmp_s[MSB]; z = (cmp_s[MSB:0] == '0); end
      OP_BIT:  begin n = mem_in[MSB]; z = ((reg_in & mem_in) == '0); end
      default: begin n = r[MSB]; z = (r == '0); end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      n_out   <= 1'b0;
      v_out   <= 1'b0;
      z_out   <= 1'b0;
      c_out   <= 1'b0;
      flag_wr <= 4'b0000;
    end else begin
      result  <= r;
      n_out   <= m[3] ? n : n_in;
      v_out   <= m[2] ? v : v_in;
      z_out   <= m[1] ? z : z_in;
      c_out   <= m[0] ? c : c_in;
      flag_wr <= m;
    end
  end
endmodule

// File: rtl/alu_flags_chk.sv
`timescale 1ns/1ps
module alu_flags_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic [W-1:0] reg_in,
  input logic [W-1:0] mem_in,
  input logic         c_in,
  input logic         n_in,
  input logic         v_in,
  input logic         z_in,
  input logic [W-1:0] result,
  input logic         n_out,
  input logic         v_out,
  input logic         z_out,
  input logic         c_out,
  input logic [3:0]   flag_wr
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && flag_wr == 4'b0000 && !c_out && !z_out && !n_out && !v_out));

  a_r12_c_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_wr[0] || c_out == $past(c_in)));

  a_r12_v_held: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flag_wr[2] || v_out == $past(v_in)));

  a_r8_inc_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7) |=> (result == W'($past(reg_in) + 1'b1) && c_out == $past(c_in)));

  a_r6_bit_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd3) |=> (result == $past(reg_in) && !flag_wr[0]));

  a_r5_cmp_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd2 && reg_in == mem_in) |=> (z_out && c_out && !n_out));

  a_r11_spare_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 4'd12) |=> (flag_wr == 4'b0000 && result == $past(reg_in)));
endmodule

bind alu_flags alu_flags_chk #(.W(W)) u_alu_flags_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .reg_in(reg_in), .mem_in(mem_in),
  .c_in(c_in), .n_in(n_in), .v_in(v_in), .z_in(z_in),
  .result(result), .n_out(n_out), .v_out(v_out), .z_out(z_out),
  .c_out(c_out), .flag_wr(flag_wr)
);

// File: tb/test_alu_flags.sv
`timescale 1ns/1ps
module test_alu_flags;
  localparam int W = 4;
  localparam int M = 1 << W;
  localparam int H = M / 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] reg_in = '0, mem_in = '0;
  logic         c_in = 1'b0, n_in = 1'b0, v_in = 1'b0, z_in = 1'b0;
  logic [W-1:0] result;
  logic         n_out, v_out, z_out, c_out;
  logic [3:0]   flag_wr;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  alu_flags #(.W(W)) i_alu_flags (
    .clk(clk), .rst_n(rst_n), .op(op), .reg_in(reg_in), .mem_in(mem_in),
    .c_in(c_in), .n_in(n_in), .v_in(v_in), .z_in(z_in),
    .result(result), .n_out(n_out), .v_out(v_out), .z_out(z_out),
    .c_out(c_out), .flag_wr(flag_wr)
  );

  function automatic string tag(int o);
    case (o)
      0: return "R3/R2/R12";
      1: return "R4/R2/R12";
      2: return "R5/R2/R12";
      3: return "R6/R2/R12";
      4, 5, 6: return "R7/R2/R12";
      7, 8: return "R8/R2/R12";
      9, 10: return "R9/R2/R12";
      11, 12: return "R10/R2/R12";
      default: return "R11/R2/R12";
    endcase
  endfunction

  function automatic int sgn(int x);
    return (x >= H) ? x - M : x;
  endfunction

  task automatic run_vec(int o, int r, int m, int c, int fi);
    int er, en, ev, ez, ec, mk, s;
    logic [W+7:0] act, exp;
    @(negedge clk);
    op = 4'(o); reg_in = W'(r); mem_in = W'(m); c_in = c[0];
    n_in = fi[2]; v_in = fi[1]; z_in = fi[0];
    er = r; en = fi[2]; ev = fi[1]; ez = fi[0]; ec = c; mk = 0;
    case (o)
      0: begin
        s = r + m + c; er = s % M; ec = int'(s >= M);
        s = sgn(r) + sgn(m) + c; ev = int'(s > H - 1 || s < -H); mk = 15;
      end
      1: begin
        s = r - m - (1 - c); er = (s + 2 * M) % M; ec = int'(s >= 0);
        s = sgn(r) - sgn(m) - (1 - c); ev = int'(s > H - 1 || s < -H); mk = 15;
      end
      2: begin ec = int'(r >= m); ez = int'(r == m); en = int'(((r - m + M) % M) >= H); mk = 11; end
      3: begin ez = int'((r & m) == 0); ev = (m / (H / 2)) % 2; en = int'(m >= H); mk = 14; end
      4: begin er = r & m; mk = 10; end
      5: begin er = r | m; mk = 10; end
      6: begin er = r ^ m; mk = 10; end
      7: begin er = (r + 1) % M; mk = 10; end
      8: begin er = (r + M - 1) % M; mk = 10; end
      9:  begin er = (2 * r) % M;     ec = int'(r >= H); mk = 11; end
      10: begin er = r / 2;           ec = r % 2;        mk = 11; end
      11: begin er = (2 * r + c) % M; ec = int'(r >= H); mk = 11; end
      12: begin er = r / 2 + c * H;   ec = r % 2;        mk = 11; end
      default: ;
    endcase
    if (o < 2 || (o > 3 && o < 13)) begin en = int'(er >= H); ez = int'(er == 0); end
    @(negedge clk);
    act = {result, n_out, v_out, z_out, c_out, flag_wr};
    exp = {W'(er), en[0], ev[0], ez[0], ec[0], 4'(mk)};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%0d r=%0d m=%0d c=%0d: got res=%0d nvzc=%b mask=%b, expected res=%0d nvzc=%b mask=%b",
               tag(o), o, r, m, c, act[W+7:8], act[7:4], act[3:0], exp[W+7:8], exp[7:4], exp[3:0]);
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    op = 4'd0; reg_in = '1; mem_in = '1; c_in = 1'b1; n_in = 1'b1; v_in = 1'b1; z_in = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({result, n_out, v_out, z_out, c_out, flag_wr} !== '0) begin
      failures++;
      $display("FAIL R1 reset: got res=%0d nvzc=%b mask=%b, expected all zero",
               result, {n_out, v_out, z_out, c_out}, flag_wr);
    end
    rst_n = 1'b1;
    for (int o = 0; o < 16; o++)
      for (int r = 0; r < M; r++)
        for (int m = 0; m < M; m++)
          for (int c = 0; c < 2; c++)
            run_vec(o, r, m, c, (r + 3 * m + o + 5 * c) % 8);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule